// File: doc/BRIEF.md
# Per-Channel Conversion Trigger Selector

This block decides, for each of eight converter channels (numbered 8 to 15), which trigger starts a conversion on that channel. Software programs a 32-bit selection word that holds one 4-bit source code per channel. For every channel the block turns the chosen source into a start request. The sources are: nothing, a one-shot software pulse, a software level, a scan trigger gated by that channel's scan-membership bit, a synchronous trigger input, and eleven external event inputs.

Software reaches the block through a small register port with three words: control, trigger selection and scan membership. Writes to the selection word are refused while the converter is enabled, and such a refused write returns a bus error. A global override bit in the control word turns off every channel's request at once, so that the sequencer can run conversions under direct software control.

Top module: `conv_trig_router`

## Requirements
- R1: After reset the control word, the selection word and the scan-membership word all read 0, and no start request is active.
- R2: Channel 8+i takes its source code from bits [4i+3:4i] of the selection word (address 1). Reading address 1 returns the stored word in the same cycle that `reg_rd` is high.
- R3: A channel whose code is 0000 never asserts its start request.
- R4: Code 0001 selects the one-shot software trigger. Writing control (address 0) with bit 4 set makes every channel with code 0001 request for exactly the one cycle after the write. Bit 4 reads 1 in that cycle and clears itself on the next.
- R5: Code 0010 requests the channel for as long as the level software bit (control bit 3) is 1.
- R6: Code 0011 requests the channel while `scan_trig` is high, but only if scan-membership bit i (address 2, bit i for channel 8+i) is 1.
- R7: Code 0100 requests the channel while `sync_trig` is high.
- R8: Codes 0101 to 1111 select `evt_trig[code-5]`. They pass it only while event-start enable (control bit 2) is 1, and otherwise act as code 0000.
- R9: While converter enable (control bit 0) is 1, a write to address 1 raises `reg_err` in the same cycle and leaves the stored selection word unchanged. No other access raises `reg_err`.
- R10: While the override bit (control bit 1) is 1, every start request is 0, whatever codes are stored.
- R11: Reading address 0 returns {pulse, level, event enable, override, enable} in bits [4:0]. Reading address 2 returns the membership mask in bits [7:0]. All other read bits, and reads of address 3, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| reg_err | output | 1 | Bus error for a refused write, same cycle |
| scan_trig | input | 1 | Scan trigger |
| sync_trig | input | 1 | Synchronous trigger |
| evt_trig | input | 11 | External event triggers |
| start_req | output | 8 | Start-conversion request, bit i for channel 8+i |

## Verification
A wrong stored code or a wrong field slice shows up as a request on the wrong channel, or from the wrong source. It appears in the first cycle in which that source differs from the correct one, and the bench varies all sources every cycle. A one-shot bit that fails to clear shows as a second pulse cycle one clock after the first. A selection word changed by a refused write shows in the next readback and in the channel's next request. The bench checks every cycle against a behavioural model, after every selection word in which each code sits on each channel.

// File: rtl/trig_sel_pkg.sv
// Shared constants for the per-channel conversion trigger selector.
// Assumes 4-bit source codes and a two-bit word address on the register port.
package trig_sel_pkg;

    // Register word addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SEL  = 2'd1;
    localparam logic [1:0] ADDR_SCAN = 2'd2;

    // Control word bit positions
    localparam int CB_ENABLE   = 0;
    localparam int CB_OVERRIDE = 1;
    localparam int CB_EVT_EN   = 2;
    localparam int CB_LEVEL    = 3;
    localparam int CB_PULSE    = 4;
    localparam int CTRL_W      = 5;

    // Source codes
    localparam int SRC_NONE     = 0;
    localparam int SRC_SW_PULSE = 1;
    localparam int SRC_SW_LEVEL = 2;
    localparam int SRC_SCAN     = 3;
    localparam int SRC_SYNC     = 4;
    localparam int SRC_EVT_BASE = 5;

    // Control state held by the register file
    typedef struct packed {
        logic pulse;
        logic level;
        logic evt_en;
        logic override;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/trig_sel_regs.sv
// Register file of the trigger selector: control, trigger selection and scan
// membership. The selection word is locked while the converter is enabled;
// a write to it then returns a bus error. The one-shot pulse bit lasts one
// cycle unless it is written again. Assumes single-cycle, unstalled accesses.
module trig_sel_regs
    import trig_sel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 4,
    localparam int DATA_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic [DATA_W-1:0] sel_word,
    output logic [NUM_CH-1:0] scan_mask,
    output ctrl_t             ctrl
);

    logic wr_ctrl;
    logic wr_sel;
    logic wr_scan;
    logic sel_locked;

    // Decode the write strobes per address
    always_comb begin
        wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
        wr_sel     = reg_wr && (reg_addr == ADDR_SEL);
        wr_scan    = reg_wr && (reg_addr == ADDR_SCAN);
        sel_locked = ctrl.enable;
    end

    // Control word, with the one-shot bit clearing itself after a cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.enable   <= reg_wdata[CB_ENABLE];
            ctrl.override <= reg_wdata[CB_OVERRIDE];
            ctrl.evt_en   <= reg_wdata[CB_EVT_EN];
            ctrl.level    <= reg_wdata[CB_LEVEL];
            ctrl.pulse    <= reg_wdata[CB_PULSE];
        end else begin
            ctrl.pulse    <= 1'b0;
        end
    end

    // Selection word, which is written only while the converter is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_word <= '0;
        end else if (wr_sel && !sel_locked) begin
            sel_word <= reg_wdata;
        end
    end

    // Scan-membership mask, one bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_mask <= '0;
        end else if (wr_scan) begin
            scan_mask <= reg_wdata[NUM_CH-1:0];
        end
    end

    // Error response for a refused selection write
    always_comb begin
        reg_err = wr_sel && sel_locked;
    end

    // Read multiplexer, zero when idle or for an unmapped address
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
                ADDR_SEL:  reg_rdata             = sel_word;
                ADDR_SCAN: reg_rdata[NUM_CH-1:0] = scan_mask;
                default:   reg_rdata             = '0;
            endcase
        end
    end

endmodule

// File: rtl/trig_sel_chan.sv
// One channel's source multiplexer. It turns the channel's code and the
// shared trigger sources into a start request. It assumes that the codes
// above the synchronous code map one to one onto the event inputs.
module trig_sel_chan
    import trig_sel_pkg::*;
#(
    parameter int CODE_W  = 4,
    localparam int NUM_EVT = (1 << CODE_W) - SRC_EVT_BASE
) (
    input  logic [CODE_W-1:0]  code,
    input  logic               sw_pulse,
    input  logic               sw_level,
    input  logic               scan_trig,
    input  logic               scan_member,
    input  logic               sync_trig,
    input  logic               evt_en,
    input  logic [NUM_EVT-1:0] evt_trig,
    input  logic               override,
    output logic               req
);

    logic [CODE_W-1:0] evt_idx;
    logic              picked;

    // Select the source named by the code
    always_comb begin
        evt_idx = code - CODE_W'(SRC_EVT_BASE);
        case (int'(code))
            SRC_NONE:     picked = 1'b0;
            SRC_SW_PULSE: picked = sw_pulse;
            SRC_SW_LEVEL: picked = sw_level;
            SRC_SCAN:     picked = scan_trig && scan_member;
            SRC_SYNC:     picked = sync_trig;
            default:      picked = evt_en && evt_trig[evt_idx];
        endcase
    end

    // The global override silences every per-channel choice
    always_comb begin
        req = picked && !override;
    end

endmodule

// File: rtl/conv_trig_router.sv
// Top of the per-channel conversion trigger selector. It ties the register
// file to one source multiplexer per channel. Requests are combinational from
// the register state and the trigger inputs. It assumes the trigger inputs
// are synchronous to clk.
module conv_trig_router
    import trig_sel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 4,
    localparam int DATA_W  = NUM_CH * CODE_W,
    localparam int NUM_EVT = (1 << CODE_W) - SRC_EVT_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               reg_err,
    input  logic               scan_trig,
    input  logic               sync_trig,
    input  logic [NUM_EVT-1:0] evt_trig,
    output logic [NUM_CH-1:0]  start_req
);

    logic [DATA_W-1:0] sel_word;
    logic [NUM_CH-1:0] scan_mask;
    ctrl_t             ctrl;
    logic              cfg_enable;
    logic              cfg_override;
    logic              cfg_evt_en;
    logic              cfg_level;
    logic              sw_pulse;

    trig_sel_regs #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .sel_word  (sel_word),
        .scan_mask (scan_mask),
        .ctrl      (ctrl)
    );

    // Unpack the control fields for the channels and the checker
    always_comb begin
        cfg_enable   = ctrl.enable;
        cfg_override = ctrl.override;
        cfg_evt_en   = ctrl.evt_en;
        cfg_level    = ctrl.level;
        sw_pulse     = ctrl.pulse;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        trig_sel_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .code        (sel_word[i*CODE_W +: CODE_W]),
            .sw_pulse    (sw_pulse),
            .sw_level    (cfg_level),
            .scan_trig   (scan_trig),
            .scan_member (scan_mask[i]),
            .sync_trig   (sync_trig),
            .evt_en      (cfg_evt_en),
            .evt_trig    (evt_trig),
            .override    (cfg_override),
            .req         (start_req[i])
        );
    end

endmodule

// File: rtl/conv_trig_router_chk.sv
// Property checker for the trigger selector. It is bound into the top and
// watches the register port, the stored state and the request outputs.
module conv_trig_router_chk #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [1:0]               reg_addr,
    input logic [NUM_CH*CODE_W-1:0] reg_wdata,
    input logic                     reg_err,
    input logic [NUM_CH*CODE_W-1:0] sel_word,
    input logic                     cfg_enable,
    input logic                     cfg_override,
    input logic                     cfg_evt_en,
    input logic                     sw_pulse,
    input logic [NUM_CH-1:0]        start_req
);

    // R9: a write to the locked selection word is answered with an error
    p_lock_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && cfg_enable) |-> reg_err);

    // R9: the refused write leaves the selection word unchanged
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && cfg_enable) |=> $stable(sel_word));

    // R9: no error without a locked selection write
    p_err_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd1 && cfg_enable) |-> !reg_err);

    // R4: the one-shot bit lasts a single cycle unless it is written again
    p_pulse_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pulse && !(reg_wr && reg_addr == 2'd0 && reg_wdata[4])) |=> !sw_pulse);

    // R10: the override silences every channel
    p_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_override |-> (start_req == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R3: a channel with code zero stays quiet
        p_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_word[i*CODE_W +: CODE_W] == '0) |-> !start_req[i]);

        // R8: event codes are blocked while the event enable is off
        p_evt_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_evt_en && int'(sel_word[i*CODE_W +: CODE_W]) >= 5) |-> !start_req[i]);
    end

endmodule

bind conv_trig_router conv_trig_router_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_err      (reg_err),
    .sel_word     (sel_word),
    .cfg_enable   (cfg_enable),
    .cfg_override (cfg_override),
    .cfg_evt_en   (cfg_evt_en),
    .sw_pulse     (sw_pulse),
    .start_req    (start_req)
);

// File: tb/conv_trig_router_tb.sv
// Bench for the trigger selector. A behavioural model is updated on each
// rising edge, and the outputs are compared with it on each falling edge.
module conv_trig_router_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        scan_trig = 1'b0;
    logic        sync_trig = 1'b0;
    logic [10:0] evt_trig = '0;
    logic [7:0]  start_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    bit [31:0] m_sel;
    bit [7:0]  m_scan;
    bit        m_en, m_ovr, m_evt, m_lvl, m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_trig_router u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .scan_trig (scan_trig),
        .sync_trig (sync_trig),
        .evt_trig  (evt_trig),
        .start_req (start_req)
    );

    // Model update at the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_scan = 0;
            m_en = 0; m_ovr = 0; m_evt = 0; m_lvl = 0; m_pulse = 0;
        end else begin
            bit next_pulse;
            next_pulse = 0;
            if (reg_wr && reg_addr == 2'd1 && !m_en) m_sel = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_scan = reg_wdata[7:0];
            if (reg_wr && reg_addr == 2'd0) begin
                m_en  = reg_wdata[0]; m_ovr = reg_wdata[1];
                m_evt = reg_wdata[2]; m_lvl = reg_wdata[3];
                next_pulse = reg_wdata[4];
            end
            m_pulse = next_pulse;
        end
    end

    function automatic bit exp_req(int ch);
        int code;
        code = int'((m_sel >> (4*ch)) & 32'hF);
        if (m_ovr) return 0;
        case (code)
            0: return 0;
            1: return m_pulse;
            2: return m_lvl;
            3: return scan_trig && m_scan[ch];
            4: return sync_trig;
            default: return m_evt && evt_trig[code-5];
        endcase
    endfunction

    function automatic string tag_for(int ch);
        int code;
        code = int'((m_sel >> (4*ch)) & 32'hF);
        if (m_ovr) return "R10";
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Compare the outputs with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [31:0] exp_rd;
            bit exp_err;
            for (int ch = 0; ch < 8; ch++) begin
                checks++;
                if (start_req[ch] !== exp_req(ch)) begin
                    errors++;
                    $display("FAIL %s channel %0d start_req actual %0b expected %0b",
                             tag_for(ch), ch + 8, start_req[ch], exp_req(ch));
                end
            end
            exp_err = reg_wr && reg_addr == 2'd1 && m_en;
            checks++;
            if (reg_err !== exp_err) begin
                errors++;
                $display("FAIL R9 reg_err actual %0b expected %0b", reg_err, exp_err);
            end
            exp_rd = 0;
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: exp_rd = {27'd0, m_pulse, m_lvl, m_evt, m_ovr, m_en};
                    2'd1: exp_rd = m_sel;
                    2'd2: exp_rd = {24'd0, m_scan};
                    default: exp_rd = 0;
                endcase
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s reg_rdata addr %0d actual %h expected %h",
                         (reg_addr == 2'd1) ? "R2" : "R11", reg_addr, reg_rdata, exp_rd);
            end
        end
    end

    task automatic idle_cycle();
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic write_reg(input bit [1:0] a, input bit [31:0] d);
        reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic read_reg(input bit [1:0] a);
        reg_rd = 1; reg_wr = 0; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic rand_inputs();
        scan_trig = 1'($urandom);
        sync_trig = 1'($urandom);
        evt_trig  = 11'($urandom);
    endtask

    task automatic direct_check(input string tag, input bit [7:0] exp);
        @(negedge clk);
        checks++;
        if (start_req !== exp) begin
            errors++;
            $display("FAIL %s start_req actual %h expected %h", tag, start_req, exp);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: the reset state is all zeros with no requests
        @(negedge clk);
        checks++;
        if (start_req !== 8'h00) begin
            errors++;
            $display("FAIL R1 start_req after reset actual %h expected 00", start_req);
        end
        @(posedge clk); #1;
        read_reg(2'd0); read_reg(2'd1); read_reg(2'd2); read_reg(2'd3);

        // R2: a mixed selection word with each field on its own channel
        write_reg(2'd1, 32'h90F5_4321);
        write_reg(2'd2, 32'h0000_0004);
        read_reg(2'd1);
        read_reg(2'd2);

        // R7: synchronous trigger drives channel 11 only
        scan_trig = 0; sync_trig = 1; evt_trig = 0;
        direct_check("R7", 8'h08);
        sync_trig = 0;

        // R4: a one-shot pulse lasts exactly one cycle on channel 8
        write_reg(2'd0, 32'h10);
        direct_check("R4", 8'h01);
        direct_check("R4", 8'h00);

        // R5: the level trigger holds channel 9 while set
        write_reg(2'd0, 32'h08);
        direct_check("R5", 8'h02);
        direct_check("R5", 8'h02);
        write_reg(2'd0, 32'h00);

        // R6: the scan trigger passes only for a member channel
        scan_trig = 1;
        direct_check("R6", 8'h04);
        write_reg(2'd2, 32'h0000_0000);
        direct_check("R6", 8'h00);
        scan_trig = 0;

        // R8: events are blocked until the event enable is set
        evt_trig = 11'h7FF;
        direct_check("R8", 8'h00);
        write_reg(2'd0, 32'h04);
        direct_check("R8", 8'hB0);
        evt_trig = 11'h010;
        direct_check("R8", 8'h80);

        // R10: the override silences every channel
        evt_trig = 11'h7FF; sync_trig = 1;
        write_reg(2'd0, 32'h0E);
        direct_check("R10", 8'h00);
        sync_trig = 0;

        // R9: the locked selection word refuses a write
        write_reg(2'd0, 32'h05);
        write_reg(2'd1, 32'hFFFF_FFFF);
        read_reg(2'd1);
        write_reg(2'd2, 32'h0000_00FF);
        read_reg(2'd2);
        write_reg(2'd0, 32'h00);
        write_reg(2'd1, 32'h1111_1111);
        read_reg(2'd1);

        // Every code on every channel under random traffic
        for (int base = 0; base < 16; base++) begin
            bit [31:0] w;
            w = 0;
            for (int ch = 0; ch < 8; ch++) w[4*ch +: 4] = 4'((base + ch) % 16);
            write_reg(2'd0, 32'h00);
            write_reg(2'd1, w);
            write_reg(2'd2, $urandom);
            for (int cyc = 0; cyc < 60; cyc++) begin
                int op;
                rand_inputs();
                op = int'($urandom % 10);
                if (op == 0)      write_reg(2'd0, {27'd0, 5'($urandom) & 5'h1E});
                else if (op == 1) write_reg(2'd0, 32'h10 | ($urandom & 32'h0C));
                else if (op == 2) read_reg(2'($urandom));
                else if (op == 3) write_reg(2'd2, $urandom);
                else              idle_cycle();
            end
            // R9 under traffic: a locked write attempt, then the readback
            write_reg(2'd0, 32'h05);
            write_reg(2'd1, ~w);
            read_reg(2'd1);
        end

        idle_cycle();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule